// File: doc/BRIEF.md
# In-Order Four-Engine Result Merger

This block sits behind four parallel processing engines that receive work from a common distributor. Each time the distributor hands an item to an engine, it also tells the merger which engine took it. The engines may finish in any relative order. Each engine delivers its results on its own valid/ready stream. The merger buffers each engine's results in a private FIFO and keeps a FIFO of engine IDs in issue order. It releases results on a single valid/ready output stream strictly in the order the work was issued.

Release is governed by a two-state machine around a registered output stage. In `ST_IDLE` the output stage is empty. The transition *load* (`ST_IDLE` to `ST_HOLD`) fires when the engine named at the head of the issue-order FIFO has a result waiting. In `ST_HOLD` the stage presents an item. The transition *reload* (`ST_HOLD` to `ST_HOLD`) fires when the item is taken and the next in-order result is already waiting. The transition *stall* (`ST_HOLD` to `ST_HOLD`) holds the item while the consumer is not ready. The transition *drain* (`ST_HOLD` to `ST_IDLE`) fires when the item is taken and nothing is waiting.

The issue-order FIFO depth is `2**ORDER_AW`. `ORDER_AW` may be set from 1 to 16, so a full-size build can hold 65,536 outstanding items. Each result FIFO depth is `2**RES_AW`. A synchronous active-high reset empties every FIFO and the output stage.

Top module: `ordered_merge`

## Requirements
- R1: While `rst` is high at a clock edge, every FIFO and the output stage are emptied. In the first cycle after reset, `out_valid` is 0, `disp_ready` is 1 and `eng_ready` is 4'b1111.
- R2: Output items appear in the order their engine IDs were accepted on the dispatch port. The n-th result accepted from engine e pairs with the n-th dispatch that named engine e (engine encoding 0..3 on `disp_eng`), whatever the order in which engines complete.
- R3: `out_valid` stays 0 while the engine at the head of the issue order has no buffered result, even if other engines hold results.
- R4: `disp_ready` is 0 exactly when the issue-order FIFO holds `2**ORDER_AW` IDs. With no results released, 2**ORDER_AW dispatches (16 by default) are accepted, and a dispatch offered while `disp_ready` is 0 adds no item to the output stream.
- R5: `eng_ready[e]` is 0 exactly when engine e's result FIFO holds `2**RES_AW` entries. With the output stalled, engine e gets `2**RES_AW + 1` results accepted (5 by default, one in the output stage). Other engines' ready bits are unaffected.
- R6: `out_last` equals the `eng_last` bit that accompanied the released result. It is neither altered nor regenerated.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R8: When in-order results are already buffered and `out_ready` stays 1, one item is released in every consecutive cycle.
- R9: A reset applied while items are queued discards them all. No item issued before the reset appears afterwards, and new work flows normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| disp_valid | input | 1 | Distributor reports one dispatched item |
| disp_ready | output | 1 | Issue-order FIFO can record a dispatch |
| disp_eng | input | 2 | Engine (0..3) that received the item |
| eng_valid | input | 4 | Per-engine result valid, bit e for engine e |
| eng_ready | output | 4 | Per-engine result FIFO has space |
| eng_data | input | 4*DATA_W | Per-engine result payloads, engine e in bits [e*DATA_W +: DATA_W] |
| eng_last | input | 4 | Per-engine end-of-batch flags |
| out_valid | output | 1 | Merged output holds an item |
| out_ready | input | 1 | Consumer accepts the merged item |
| out_data | output | DATA_W | Merged result payload |
| out_last | output | 1 | End-of-batch flag of the merged item |

## Verification
Two functions of this block can coincide in one cycle. A new dispatch can be written into the issue-order FIFO while the release logic pops its head. An engine can push into its result FIFO while the output stage drains that same FIFO. The stimulus table provokes both by issuing and completing work while `out_ready` is high, with several engines finishing in reverse issue order. Every released item is compared against the model of dispatch order and per-engine completion count. A lost or duplicated entry, or a corrupted occupancy count, shows up as a wrong payload or a missing item at the end of the drain.

// File: rtl/omerge_pkg.sv
package omerge_pkg;
    localparam int NUM_ENG = 4;
    localparam int ENG_IDW = 2;

    typedef logic [ENG_IDW-1:0] eng_id_t;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } rel_state_t;
endpackage

// File: rtl/omerge_fifo.sv
module omerge_fifo #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int          DEPTH    = 1 << AW;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   occ;
    logic          do_wr;
    logic          do_rd;

    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    // pointer and occupancy state
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    // storage array, no reset needed
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (occ == '0);
    assign full    = (occ == FULL_CNT);
endmodule

// File: rtl/omerge_release.sv
module omerge_release
    import omerge_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          order_empty,
    input  eng_id_t                       head_eng,
    input  logic [NUM_ENG-1:0]            res_empty,
    input  logic [NUM_ENG*(DATA_W+1)-1:0] res_word,
    input  logic                          out_ready,
    output logic                          pop,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             out_data,
    output logic                          out_last
);
    localparam int WW = DATA_W + 1;

    rel_state_t    state;
    rel_state_t    state_nx;
    logic          cand;
    logic [WW-1:0] head_word;
    logic [WW-1:0] hold_word;

    assign head_word = res_word[head_eng*WW +: WW];
    assign cand      = !order_empty && !res_empty[head_eng];

    // next state and pop decision
    always_comb begin
        state_nx = state;
        pop      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cand) begin
                    pop      = 1'b1;
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    if (cand) begin
                        pop      = 1'b1;
                        state_nx = ST_HOLD;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // output stage register
    always_ff @(posedge clk) begin
        if (rst)      hold_word <= '0;
        else if (pop) hold_word <= head_word;
    end

    assign out_valid = (state == ST_HOLD);
    assign out_data  = hold_word[DATA_W-1:0];
    assign out_last  = hold_word[DATA_W];
endmodule

// File: rtl/ordered_merge.sv
module ordered_merge
    import omerge_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ORDER_AW = 4,
    parameter int RES_AW   = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        disp_valid,
    output logic                        disp_ready,
    input  logic [ENG_IDW-1:0]          disp_eng,
    input  logic [NUM_ENG-1:0]          eng_valid,
    output logic [NUM_ENG-1:0]          eng_ready,
    input  logic [NUM_ENG*DATA_W-1:0]   eng_data,
    input  logic [NUM_ENG-1:0]          eng_last,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [DATA_W-1:0]           out_data,
    output logic                        out_last
);
    localparam int WW = DATA_W + 1;

    logic                     order_full;
    logic                     order_empty;
    eng_id_t                  head_eng;
    logic                     pop;
    logic [NUM_ENG-1:0]       res_empty;
    logic [NUM_ENG-1:0]       res_full;
    logic [NUM_ENG*WW-1:0]    res_word;

    assign disp_ready = !order_full;

    omerge_fifo #(
        .W  (ENG_IDW),
        .AW (ORDER_AW)
    ) u_order (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (disp_valid && disp_ready),
        .wr_data (disp_eng),
        .rd_en   (pop),
        .rd_data (head_eng),
        .empty   (order_empty),
        .full    (order_full)
    );

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        logic pop_e;
        assign pop_e        = pop && (head_eng == ENG_IDW'(e));
        assign eng_ready[e] = !res_full[e];

        omerge_fifo #(
            .W  (WW),
            .AW (RES_AW)
        ) u_res (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (eng_valid[e] && eng_ready[e]),
            .wr_data ({eng_last[e], eng_data[e*DATA_W +: DATA_W]}),
            .rd_en   (pop_e),
            .rd_data (res_word[e*WW +: WW]),
            .empty   (res_empty[e]),
            .full    (res_full[e])
        );
    end

    omerge_release #(
        .DATA_W (DATA_W)
    ) u_rel (
        .clk         (clk),
        .rst         (rst),
        .order_empty (order_empty),
        .head_eng    (head_eng),
        .res_empty   (res_empty),
        .res_word    (res_word),
        .out_ready   (out_ready),
        .pop         (pop),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last)
    );
endmodule

// File: rtl/ordered_merge_chk.sv
module ordered_merge_chk
    import omerge_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ORDER_AW = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               disp_valid,
    input logic               disp_ready,
    input logic [NUM_ENG-1:0] eng_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [DATA_W-1:0]  out_data,
    input logic               out_last
);
    localparam int              DEPTH    = 1 << ORDER_AW;
    localparam logic [ORDER_AW+1:0] DEPTH_V  = (ORDER_AW+2)'(DEPTH);
    localparam logic [ORDER_AW+1:0] DEPTH_P1 = (ORDER_AW+2)'(DEPTH + 1);

    // items issued but not yet released (includes the output stage)
    logic [ORDER_AW+1:0] outstanding;
    logic                acc_in;
    logic                acc_out;

    assign acc_in  = disp_valid && disp_ready;
    assign acc_out = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) outstanding <= '0;
        else begin
            unique case ({acc_in, acc_out})
                2'b10:   outstanding <= outstanding + 1'b1;
                2'b01:   outstanding <= outstanding - 1'b1;
                default: outstanding <= outstanding;
            endcase
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && disp_ready && (eng_ready == '1)));

    assert_no_release_without_issue_R3: assert property (@(posedge clk) disable iff (rst)
        (outstanding == '0) |-> !out_valid);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        acc_in |-> (outstanding < DEPTH_P1));

    assert_ready_low_only_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        !disp_ready |-> (outstanding >= DEPTH_V));

    assert_hold_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    assert_hold_payload_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_last)));
endmodule

bind ordered_merge ordered_merge_chk #(
    .DATA_W   (DATA_W),
    .ORDER_AW (ORDER_AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .eng_ready  (eng_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last)
);

// File: tb/ordered_merge_test.sv
module ordered_merge_test;
    localparam int DW       = 16;
    localparam int ORDER_AW = 4;
    localparam int RES_AW   = 2;
    localparam int NE       = 4;
    localparam int QMAX     = 512;

    // row: [7] dispatch, [6:5] engine, [4:1] engines that complete, [0] out_ready
    localparam int NVEC = 22;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_00_0000_0, 8'b1_01_0000_0, 8'b1_10_0000_0, 8'b1_11_1000_0,
        8'b1_00_1110_1, 8'b1_01_0001_1, 8'b0_00_1111_1, 8'b1_10_0010_0,
        8'b1_10_0100_0, 8'b1_11_0100_1, 8'b1_00_1000_1, 8'b1_00_0001_0,
        8'b1_01_1111_1, 8'b1_11_1111_1, 8'b1_11_0000_1, 8'b1_10_1000_1,
        8'b1_01_0100_1, 8'b1_00_0010_1, 8'b0_00_1111_1, 8'b1_00_1111_1,
        8'b0_00_1111_1, 8'b0_00_1111_1
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              disp_valid = 1'b0;
    logic              disp_ready;
    logic [1:0]        disp_eng = '0;
    logic [NE-1:0]     eng_valid = '0;
    logic [NE-1:0]     eng_ready;
    logic [NE*DW-1:0]  eng_data = '0;
    logic [NE-1:0]     eng_last = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DW-1:0]     out_data;
    logic              out_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int exp_data [QMAX];
    bit exp_last [QMAX];
    int wr_idx, rd_idx, out_cnt;
    int disp_cnt [NE];
    int eng_sent [NE];

    always #5 clk = ~clk;

    ordered_merge #(
        .DATA_W   (DW),
        .ORDER_AW (ORDER_AW),
        .RES_AW   (RES_AW)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .disp_valid (disp_valid),
        .disp_ready (disp_ready),
        .disp_eng   (disp_eng),
        .eng_valid  (eng_valid),
        .eng_ready  (eng_ready),
        .eng_data   (eng_data),
        .eng_last   (eng_last),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_clear();
        wr_idx = 0; rd_idx = 0; out_cnt = 0;
        for (int e = 0; e < NE; e++) begin
            disp_cnt[e] = 0;
            eng_sent[e] = 0;
        end
    endtask

    // account handshakes of the coming edge, then move to the next falling edge
    task automatic tick();
        if (!rst) begin
            if (out_valid && out_ready) begin
                if (rd_idx >= wr_idx)
                    chk(1'b0, "R2 unexpected output", int'(out_data), -1);
                else begin
                    chk(int'(out_data) == exp_data[rd_idx], "R2 order/payload",
                        int'(out_data), exp_data[rd_idx]);
                    chk(out_last == exp_last[rd_idx], "R6 last flag",
                        int'(out_last), int'(exp_last[rd_idx]));
                    rd_idx++;
                end
                out_cnt++;
            end
            if (disp_valid && disp_ready && wr_idx < QMAX) begin
                exp_data[wr_idx] = int'(disp_eng) * 256 + disp_cnt[disp_eng];
                exp_last[wr_idx] = (disp_cnt[disp_eng] % 3 == 2);
                disp_cnt[disp_eng]++;
                wr_idx++;
            end
            for (int e = 0; e < NE; e++)
                if (eng_valid[e] && eng_ready[e]) eng_sent[e]++;
        end
        @(negedge clk);
    endtask

    task automatic drive(input bit d_en, input int d_eng, input logic [NE-1:0] mask, input bit ordy);
        disp_valid = d_en;
        disp_eng   = 2'(d_eng);
        for (int e = 0; e < NE; e++) begin
            eng_valid[e] = mask[e] && (eng_sent[e] < disp_cnt[e]);
            eng_data[e*DW +: DW] = DW'(e * 256 + eng_sent[e]);
            eng_last[e] = (eng_sent[e] % 3 == 2);
        end
        out_ready = ordy;
        tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        disp_valid = 1'b0; eng_valid = '0; out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            bit pend = 1'b0;
            for (int e = 0; e < NE; e++) if (eng_sent[e] < disp_cnt[e]) pend = 1'b1;
            if (!pend && rd_idx == wr_idx && !out_valid) break;
            drive(0, 0, 4'hF, 1);
        end
        disp_valid = 1'b0; eng_valid = '0;
        chk(rd_idx == wr_idx, "R2 all issued items released", rd_idx, wr_idx);
    endtask

    initial begin
        model_clear();
        do_reset();
        // R1: state right after reset
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(disp_ready == 1'b1, "R1 disp_ready", int'(disp_ready), 1);
        chk(eng_ready == 4'hF, "R1 eng_ready", int'(eng_ready), 15);

        // table walk: overlapping dispatch, completion and release (R2, R6)
        for (int v = 0; v < NVEC; v++)
            drive(VEC[v][7], int'(VEC[v][6:5]), VEC[v][4:1], VEC[v][0]);
        drain();

        // R3: later engine finished, head engine not yet
        do_reset();
        drive(1, 0, 4'h0, 0);
        drive(1, 1, 4'h0, 0);
        drive(0, 0, 4'b0010, 0);
        drive(0, 0, 4'h0, 0);
        drive(0, 0, 4'h0, 0);
        drive(0, 0, 4'h0, 0);
        chk(out_valid == 1'b0, "R3 no release past missing head", int'(out_valid), 0);
        drive(0, 0, 4'b0001, 0);
        drive(0, 0, 4'h0, 0);
        chk(out_valid == 1'b1, "R3 head result released", int'(out_valid), 1);
        chk(out_data == 16'd0, "R2 head item first", int'(out_data), 0);
        // R7: stalled output holds
        drive(0, 0, 4'h0, 0);
        drive(0, 0, 4'h0, 0);
        chk(out_valid == 1'b1 && out_data == 16'd0, "R7 held under stall", int'(out_data), 0);
        drain();

        // R8: back-to-back release
        do_reset();
        for (int e = 0; e < NE; e++) drive(1, e, 4'h0, 0);
        drive(0, 0, 4'hF, 0);
        drive(0, 0, 4'h0, 0);
        for (int i = 0; i < NE; i++) begin
            chk(out_valid == 1'b1, "R8 one item per cycle", int'(out_valid), 1);
            drive(0, 0, 4'h0, 1);
        end
        chk(out_valid == 1'b0 && rd_idx == NE, "R8 four released", rd_idx, NE);

        // R4: issue-order capacity
        do_reset();
        for (int i = 0; i < (1 << ORDER_AW); i++) drive(1, i % NE, 4'h0, 0);
        chk(disp_ready == 1'b0, "R4 disp_ready low when full", int'(disp_ready), 0);
        drive(1, 3, 4'h0, 0);
        drive(1, 2, 4'h0, 0);
        chk(wr_idx == (1 << ORDER_AW), "R4 accepted dispatches", wr_idx, 1 << ORDER_AW);
        drain();
        chk(out_cnt == (1 << ORDER_AW), "R4 refused dispatch adds no item", out_cnt, 1 << ORDER_AW);

        // R5: per-engine back-pressure
        do_reset();
        for (int i = 0; i < 8; i++) drive(1, 2, 4'h0, 0);
        for (int i = 0; i < 10; i++) drive(0, 0, 4'b0100, 0);
        chk(eng_sent[2] == (1 << RES_AW) + 1, "R5 accepted results", eng_sent[2], (1 << RES_AW) + 1);
        chk(eng_ready == 4'b1011, "R5 only engine 2 stalled", int'(eng_ready), 11);
        drain();

        // R9: reset while items are queued
        do_reset();
        drive(1, 1, 4'h0, 0);
        drive(1, 3, 4'h0, 0);
        drive(0, 0, 4'hF, 0);
        drive(0, 0, 4'h0, 0);
        do_reset();
        chk(out_valid == 1'b0, "R9 queue discarded", int'(out_valid), 0);
        chk(eng_ready == 4'hF && disp_ready, "R9 FIFOs empty", int'(eng_ready), 15);
        drive(1, 3, 4'h0, 0);
        drive(0, 0, 4'b1000, 0);
        drive(0, 0, 4'h0, 0);
        chk(out_valid && out_data == 16'd768, "R9 fresh item after reset", int'(out_data), 768);
        drain();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule